// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from the core's fixed sources and from a set of peripherals. It chooses the most urgent request that is allowed to run and presents it to the processor core as a request strobe, a priority position and a vector address. Every request is captured in a pending bit and stays there until it is acknowledged. There are sixteen numbered positions, and position 0 is the most urgent. Positions 0 to 3 belong to the reset, power-down, loop/PC-stack and emulation-kernel sources. Positions 4 to 15 are twelve user slots. A separate emulator request ranks above every numbered position.

Each peripheral owns a 4-bit routing field, and software writes that field to choose which user slot the peripheral drives. After reset every field reads as unassigned. The core supplies a mask word, a global disable and a nesting mode. The controller tracks which levels are in service, using the acknowledge and return-from-interrupt pulses, so that in nested mode only a strictly more urgent request preempts the handler that is running. In sequential mode a new handler starts only after the running one has finished.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, no request is pending, nothing is in service, `irq_o` is 0 and every peripheral routing field is unassigned, so peripheral requests produce no interrupt.
- R2: When `irq_o` is 1 and `emu_o` is 0, `vec_o` equals `pos_o` × 0x20 (position 2 gives 0x040, position 15 gives 0x1E0). Bit n of `core_req_i` (n = 0..3) requests position n: 0 is reset, 1 is power-down, 2 is loop/PC stack, 3 is emulation kernel.
- R3: The lowest-numbered eligible position is presented. A pending emulator request outranks every position and is presented with `emu_o`=1, `pos_o`=0 and `vec_o`=0.
- R4: Positions 2 to 15 are eligible only while bit n of `mask_i` is 1. Positions 0 and 1 and the emulator ignore `mask_i`.
- R5: While `gdis_i` is 1, positions 1 to 15 are held off. The emulator and position 0 are still presented.
- R6: A routing field value v from 0 to 11 sends that peripheral's request to position 4+v. Values 12 to 15 mean unassigned, and such a request is dropped. Several peripherals that share a slot set one pending bit between them.
- R7: A request pulse sets its pending bit one cycle later, and the bit holds until an acknowledge clears it. An acknowledge clears only the presented request, and a request that is asserted in the acknowledge cycle sets the bit again.
- R8: In nested mode (`nest_en_i`=1), a request is presented only when it is strictly more urgent than the most urgent level in service. `rti_i` ends the most urgent in-service level, which restores the previous one.
- R9: In sequential mode (`nest_en_i`=0), while any level is in service, only the emulator or position 0 can be presented, and only when it is more urgent than that level.
- R10: `ack_i` has no effect while `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| emu_req_i | input | 1 | Emulator request pulse |
| core_req_i | input | 4 | Request pulses for positions 0 to 3 |
| periph_req_i | input | NUM_PERIPH | Peripheral request pulses, bit index = peripheral ID |
| mask_i | input | 16 | Mask word, bit n enables position n (bits 2 to 15 used) |
| gdis_i | input | 1 | Global interrupt disable |
| nest_en_i | input | 1 | 1 = nested servicing, 0 = sequential |
| map_we_i | input | 1 | Routing field write strobe |
| map_id_i | input | ID_W | Peripheral ID whose field is written |
| map_slot_i | input | 4 | New routing field value |
| ack_i | input | 1 | Acknowledge of the presented request |
| rti_i | input | 1 | Return from interrupt |
| irq_o | output | 1 | A request is presented |
| emu_o | output | 1 | The presented request is the emulator |
| pos_o | output | 4 | Presented position (0 when none or emulator) |
| vec_o | output | 9 | Vector address of the presented request |

## Verification
The assertions take three things for granted about the core. It pulses `rti_i` only while a level is in service. It never asserts `rti_i` and `ack_i` in the same cycle. It holds `mask_i` and `gdis_i` steady across the edge at which it samples the presented request. The random stimulus draws `rti_i` only when the bench's own model shows a level in service and `ack_i` is low. It changes the mask and the disable only between edges. Directed sequences cover preemption, equal-level blocking, sequential hold-off and shared slots.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    localparam int unsigned NPOS      = 16;
    localparam int unsigned NUSR      = 12;
    localparam int unsigned USR_BASE  = 4;
    localparam int unsigned NCORE     = USR_BASE;
    localparam int unsigned NRANK     = NPOS + 1;
    localparam int unsigned RANK_W    = $clog2(NRANK + 1);
    localparam int unsigned POS_W     = $clog2(NPOS);
    localparam int unsigned VEC_SHIFT = 5;
    localparam int unsigned VEC_W     = POS_W + VEC_SHIFT;
    localparam int unsigned FIELD_W   = 4;

    typedef logic [RANK_W-1:0] rank_t;

    localparam rank_t RANK_NONE = rank_t'(NRANK);
    localparam rank_t RANK_EMU  = rank_t'(0);
    localparam rank_t RANK_RST  = rank_t'(1);
    localparam logic [FIELD_W-1:0] FIELD_NONE = {FIELD_W{1'b1}};
endpackage

// File: rtl/vpic_map.sv
module vpic_map
    import vpic_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int ID_W       = 3
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_en_i,
    input  logic [ID_W-1:0]       wr_id_i,
    input  logic [FIELD_W-1:0]    wr_slot_i,
    input  logic [NUM_PERIPH-1:0] periph_req_i,
    output logic [NUSR-1:0]       slot_req_o
);
    typedef struct packed {
        logic [NUM_PERIPH-1:0][FIELD_W-1:0] field;
    } map_state_t;

    map_state_t st_d, st_q;
    logic [NUSR-1:0][NUM_PERIPH-1:0] match;

    always_comb begin
        st_d = st_q;
        if (wr_en_i && (int'(wr_id_i) < NUM_PERIPH)) begin
            st_d.field[wr_id_i] = wr_slot_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.field <= {NUM_PERIPH{FIELD_NONE}};
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar s = 0; s < NUSR; s++) begin : g_slot
        for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_per
            assign match[s][p] = periph_req_i[p] && (st_q.field[p] == FIELD_W'(s));
        end
        assign slot_req_o[s] = |match[s];
    end

    // R6: a slot can only be requested by some peripheral
    a_r6_slot_needs_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_req_o != '0) |-> (periph_req_i != '0));
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter
    import vpic_pkg::*;
(
    input  logic [NPOS-1:0] pend_i,
    input  logic            emu_i,
    input  logic [NPOS-1:0] mask_i,
    input  logic            gdis_i,
    input  logic            nest_i,
    input  rank_t           cur_rank_i,
    output logic            valid_o,
    output rank_t           sel_rank_o
);
    logic [NRANK-1:0] elig;
    rank_t            best;

    always_comb begin
        elig    = '0;
        elig[0] = emu_i;
        elig[1] = pend_i[0];
        elig[2] = pend_i[1] & ~gdis_i;
        for (int n = 2; n < NPOS; n++) begin
            elig[n+1] = pend_i[n] & mask_i[n] & ~gdis_i;
        end
        best = RANK_NONE;
        for (int r = NRANK - 1; r >= 0; r--) begin
            if (elig[r]) best = rank_t'(r);
        end
    end

    assign sel_rank_o = best;
    assign valid_o    = (best < cur_rank_i) &&
                        (nest_i || (cur_rank_i == RANK_NONE) || (best <= RANK_RST));
endmodule

// File: rtl/vpic_service.sv
module vpic_service
    import vpic_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  ack_i,
    input  rank_t ack_rank_i,
    input  logic  rti_i,
    output rank_t cur_rank_o
);
    typedef struct packed {
        logic [NRANK-1:0] isr;
    } svc_state_t;

    svc_state_t st_d, st_q;
    rank_t      cur;

    always_comb begin
        cur = RANK_NONE;
        for (int r = NRANK - 1; r >= 0; r--) begin
            if (st_q.isr[r]) cur = rank_t'(r);
        end
        st_d = st_q;
        if (rti_i && (cur != RANK_NONE)) begin
            st_d.isr[cur] = 1'b0;
        end
        if (ack_i && (ack_rank_i < RANK_NONE)) begin
            st_d.isr[ack_rank_i] = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_rank_o = cur;

    // R8: a return ends the current level and falls back to a less urgent one
    a_r8_rti_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rti_i && !ack_i && (cur_rank_o != RANK_NONE)) |=> (cur_rank_o > $past(cur_rank_o)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import vpic_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int ID_W       = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  emu_req_i,
    input  logic [3:0]            core_req_i,
    input  logic [NUM_PERIPH-1:0] periph_req_i,
    input  logic [15:0]           mask_i,
    input  logic                  gdis_i,
    input  logic                  nest_en_i,
    input  logic                  map_we_i,
    input  logic [ID_W-1:0]       map_id_i,
    input  logic [3:0]            map_slot_i,
    input  logic                  ack_i,
    input  logic                  rti_i,
    output logic                  irq_o,
    output logic                  emu_o,
    output logic [3:0]            pos_o,
    output logic [8:0]            vec_o
);
    typedef struct packed {
        logic [NPOS-1:0] pend;
        logic            emu;
    } pend_state_t;

    pend_state_t      st_d, st_q;
    logic [NUSR-1:0]  slot_req;
    logic             sel_valid;
    rank_t            sel_rank;
    rank_t            cur_rank;
    logic             ack_eff;
    logic [POS_W-1:0] sel_pos;

    vpic_map #(.NUM_PERIPH(NUM_PERIPH), .ID_W(ID_W)) u_map (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_en_i      (map_we_i),
        .wr_id_i      (map_id_i),
        .wr_slot_i    (map_slot_i),
        .periph_req_i (periph_req_i),
        .slot_req_o   (slot_req)
    );

    vpic_arbiter u_arb (
        .pend_i     (st_q.pend),
        .emu_i      (st_q.emu),
        .mask_i     (mask_i),
        .gdis_i     (gdis_i),
        .nest_i     (nest_en_i),
        .cur_rank_i (cur_rank),
        .valid_o    (sel_valid),
        .sel_rank_o (sel_rank)
    );

    vpic_service u_svc (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ack_i      (ack_eff),
        .ack_rank_i (sel_rank),
        .rti_i      (rti_i),
        .cur_rank_o (cur_rank)
    );

    assign ack_eff = ack_i && sel_valid;
    assign sel_pos = (sel_valid && (sel_rank != RANK_EMU)) ? POS_W'(sel_rank - rank_t'(1)) : '0;

    always_comb begin
        st_d = st_q;
        if (ack_eff) begin
            if (sel_rank == RANK_EMU) st_d.emu = 1'b0;
            else                      st_d.pend[sel_pos] = 1'b0;
        end
        st_d.pend = st_d.pend | {slot_req, core_req_i};
        st_d.emu  = st_d.emu | emu_req_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = sel_valid;
    assign emu_o = sel_valid && (sel_rank == RANK_EMU);
    assign pos_o = sel_pos;
    assign vec_o = {sel_pos, {VEC_SHIFT{1'b0}}};

    // R4: a presented maskable position always has its mask bit set
    a_r4_mask_honoured: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !emu_o && (pos_o >= 4'd2)) |-> mask_i[pos_o]);

    // R5: under global disable only the emulator or reset gets through
    a_r5_gdis_holds_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && gdis_i) |-> (emu_o || (pos_o == 4'd0)));

    // R8: the selection from the arbiter is strictly above the service level
    a_r8_strictly_higher: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (sel_rank < cur_rank));

    // R9: sequential mode admits only emulator or reset over a running handler
    a_r9_sequential_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !nest_en_i && (cur_rank != RANK_NONE)) |-> (sel_rank <= RANK_RST));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
    localparam int NP  = 8;
    localparam int IDW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          emu_req = 1'b0;
    logic [3:0]    core_req = '0;
    logic [NP-1:0] periph_req = '0;
    logic [15:0]   mask = 16'hFFFF;
    logic          gdis = 1'b0;
    logic          nest = 1'b1;
    logic          map_we = 1'b0;
    logic [IDW-1:0] map_id = '0;
    logic [3:0]    map_slot = '0;
    logic          ack = 1'b0;
    logic          rti = 1'b0;
    logic          irq, emu;
    logic [3:0]    pos;
    logic [8:0]    vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    logic [15:0]      m_pend;
    logic             m_emu;
    logic [16:0]      m_isr;
    logic [NP-1:0][3:0] m_field;

    always #10 clk = ~clk;

    prio_irq_ctrl #(.NUM_PERIPH(NP), .ID_W(IDW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .emu_req_i(emu_req), .core_req_i(core_req),
        .periph_req_i(periph_req), .mask_i(mask), .gdis_i(gdis), .nest_en_i(nest),
        .map_we_i(map_we), .map_id_i(map_id), .map_slot_i(map_slot),
        .ack_i(ack), .rti_i(rti), .irq_o(irq), .emu_o(emu), .pos_o(pos), .vec_o(vec)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(string tag, logic e_irq, logic e_emu, logic [3:0] e_pos, logic [8:0] e_vec);
        #1;
        checks++;
        if (irq !== e_irq || emu !== e_emu || pos !== e_pos || vec !== e_vec) begin
            failures++;
            $display("FAIL %s: irq=%0b emu=%0b pos=%0d vec=0x%03h expected irq=%0b emu=%0b pos=%0d vec=0x%03h",
                     tag, irq, emu, pos, vec, e_irq, e_emu, e_pos, e_vec);
        end
    endtask

    task automatic pulse_core(int n);
        core_req[n] = 1'b1; tick(); core_req = '0;
    endtask
    task automatic pulse_per(logic [NP-1:0] v);
        periph_req = v; tick(); periph_req = '0;
    endtask
    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask
    task automatic do_rti();
        rti = 1'b1; tick(); rti = 1'b0;
    endtask
    task automatic map_write(int id, int slot);
        map_we = 1'b1; map_id = IDW'(id); map_slot = 4'(slot); tick(); map_we = 1'b0;
    endtask

    // expected selection from the requirements: rank 0 = emulator, rank n+1 = position n
    task automatic model_eval(output logic v, output int s);
        logic [16:0] el;
        int cur;
        el = '0;
        el[0] = m_emu;
        el[1] = m_pend[0];
        el[2] = m_pend[1] & ~gdis;
        for (int n = 2; n < 16; n++) el[n+1] = m_pend[n] & mask[n] & ~gdis;
        s = 17;
        for (int r = 16; r >= 0; r--) if (el[r]) s = r;
        cur = 17;
        for (int r = 16; r >= 0; r--) if (m_isr[r]) cur = r;
        v = (s < cur) && (nest || cur == 17 || s <= 1);
    endtask

    task automatic model_reset();
        m_pend = '0; m_emu = 1'b0; m_isr = '0;
        for (int p = 0; p < NP; p++) m_field[p] = 4'hF;
    endtask

    task automatic model_step(logic v, int s);
        logic [15:0] raw;
        int cur;
        cur = 17;
        for (int r = 16; r >= 0; r--) if (m_isr[r]) cur = r;
        if (rti && cur != 17) m_isr[cur] = 1'b0;
        if (ack && v) begin
            m_isr[s] = 1'b1;
            if (s == 0) m_emu = 1'b0; else m_pend[s-1] = 1'b0;
        end
        raw = {12'b0, core_req};
        for (int p = 0; p < NP; p++)
            if (periph_req[p] && m_field[p] < 12) raw[4 + m_field[p]] = 1'b1;
        m_pend = m_pend | raw;
        m_emu = m_emu | emu_req;
        if (map_we) m_field[map_id] = map_slot;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic v;
        int s;
        logic [3:0] ep;
        void'($urandom(32'd20240611));
        repeat (3) tick();
        rst_n = 1'b1;
        check("R1 idle after reset", 0, 0, 0, 9'h000);
        pulse_per('1);
        check("R1 unassigned peripherals silent", 0, 0, 0, 9'h000);

        // R2 vectors of core positions
        pulse_core(2);
        check("R2 loop stack vector", 1, 0, 2, 9'h040);
        do_ack();
        check("R7 ack clears pending", 0, 0, 0, 9'h000);
        do_rti();

        // R3 emulator above all
        pulse_core(3);
        check("R2 kernel vector", 1, 0, 3, 9'h060);
        emu_req = 1'b1; tick(); emu_req = 1'b0;
        check("R3 emulator wins", 1, 1, 0, 9'h000);
        do_ack();
        check("R8 lower blocked under emulator", 0, 0, 0, 9'h000);
        do_rti();
        check("R8 rti restores pending kernel", 1, 0, 3, 9'h060);
        do_ack(); do_rti();

        // R4 mask, R5 global disable
        mask = '0;
        pulse_core(2);
        check("R4 masked position hidden", 0, 0, 0, 9'h000);
        mask = 16'h0004;
        check("R4 unmask shows held request", 1, 0, 2, 9'h040);
        do_ack(); do_rti();
        mask = '0;
        pulse_core(1);
        check("R4 power-down ignores mask", 1, 0, 1, 9'h020);
        gdis = 1'b1;
        check("R5 disable holds power-down", 0, 0, 0, 9'h000);
        pulse_core(0);
        check("R5 reset passes disable", 1, 0, 0, 9'h000);
        do_ack(); do_rti();
        check("R5 power-down still held", 0, 0, 0, 9'h000);
        gdis = 1'b0;
        check("R5 release shows power-down", 1, 0, 1, 9'h020);
        do_ack(); do_rti();
        mask = 16'hFFFF;

        // R6 routing
        map_write(3, 3);
        pulse_per(8'h08);
        check("R6 periph 3 to USR3", 1, 0, 7, 9'h0E0);
        do_ack(); do_rti();
        map_write(5, 14);
        pulse_per(8'h20);
        check("R6 unassigned value drops request", 0, 0, 0, 9'h000);
        map_write(1, 0); map_write(2, 0);
        pulse_per(8'h06);
        check("R6 shared slot vector", 1, 0, 4, 9'h080);
        do_ack();
        check("R6 shared slot one pending bit", 0, 0, 0, 9'h000);
        do_rti();
        map_write(4, 11);
        pulse_per(8'h10);
        check("R2 last slot vector", 1, 0, 15, 9'h1E0);
        do_ack(); do_rti();

        // R8 nesting
        pulse_per(8'h08);
        do_ack();
        pulse_core(2);
        check("R8 higher preempts", 1, 0, 2, 9'h040);
        do_ack();
        pulse_per(8'h08);
        check("R8 lower waits", 0, 0, 0, 9'h000);
        do_rti();
        check("R8 equal level not presented", 0, 0, 0, 9'h000);
        do_rti();
        check("R8 presented after return", 1, 0, 7, 9'h0E0);
        do_ack(); do_rti();

        // R9 sequential
        nest = 1'b0;
        pulse_per(8'h08);
        do_ack();
        pulse_core(2);
        check("R9 no preemption sequential", 0, 0, 0, 9'h000);
        pulse_core(0);
        check("R9 reset still preempts", 1, 0, 0, 9'h000);
        do_ack(); do_rti();
        check("R9 waits for outer handler", 0, 0, 0, 9'h000);
        do_rti();
        check("R9 runs after return", 1, 0, 2, 9'h040);
        do_ack(); do_rti();

        // R10 stray acknowledge
        do_ack();
        pulse_core(3);
        check("R10 stray ack ignored", 1, 0, 3, 9'h060);
        do_ack(); do_rti();
        nest = 1'b1;

        // R7 request in acknowledge cycle sets again
        core_req[2] = 1'b1; tick();
        ack = 1'b1; tick(); ack = 1'b0; core_req = '0;
        check("R7 equal level blocked", 0, 0, 0, 9'h000);
        do_rti();
        check("R7 set wins over clear", 1, 0, 2, 9'h040);
        do_ack(); do_rti();
        check("R7 clean afterwards", 0, 0, 0, 9'h000);

        // random phase against the model
        rst_n = 1'b0; tick(); tick();
        model_reset();
        rst_n = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            core_req   = 4'(($urandom % 16 == 0) ? (1 << ($urandom % 4)) : 0);
            emu_req    = ($urandom % 40 == 0);
            for (int p = 0; p < NP; p++) periph_req[p] = ($urandom % 12 == 0);
            if ($urandom % 50 == 0) mask = 16'($urandom);
            if ($urandom % 30 == 0) gdis = ~gdis;
            if ($urandom % 100 == 0) nest = ~nest;
            map_we   = ($urandom % 8 == 0);
            map_id   = IDW'($urandom);
            map_slot = 4'($urandom);
            ack      = ($urandom % 2 == 0);
            rti      = (m_isr != '0) && !ack && ($urandom % 3 == 0);
            model_eval(v, s);
            ep = (v && s != 0) ? 4'(s - 1) : 4'd0;
            check("R3 random selection", v, v && (s == 0), ep, {ep, 5'b0});
            model_step(v, s);
            tick();
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule